// File: doc/BRIEF.md
# Scatter-Gather Transfer Sequencer

This block expands a single scatter or gather command into the memory transfers it implies. One side of the transfer is a contiguous byte range; the other side is a set of disjoint buffers. The buffers are listed in a descriptor array, and each descriptor gives a buffer base and a buffer length. The command sets the direction (read or write) and says whether the disjoint buffers sit in far memory or in local memory. The block reads descriptors by index through a lookup port that answers in the same cycle.

When the fragments are on the far side, the block sends one far request per non-empty descriptor and lets several of them be in flight at once, up to a parameter limit. When the fragments are local, it sends a single far request that covers the whole contiguous range. It then lists the local placement of that data as a stream of segment entries, one per non-empty descriptor. In both cases a running offset into the contiguous range advances by each descriptor's length, in descriptor order. The block raises a one-cycle done pulse once every issued request has its response. The pulse carries a length-error flag when the descriptor lengths do not add up to the command's total length.

Top module: `sg_sequencer`

## Requirements
- R1: `cmd_ready` is high only while no command is in progress, including right after reset. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high.
- R2: With `cmd_far_frag`=1, each descriptor of non-zero length produces exactly one request, in descriptor order. Its `req_far_addr` is the descriptor base, its `req_len` is the descriptor length, and its `req_loc_addr` is `cmd_base` plus the sum of the lengths of the earlier descriptors.
- R3: With `cmd_far_frag`=0 and a non-zero total, exactly one request is issued, before any segment entry. It has `req_far_addr`=`cmd_base`, `req_len`=`cmd_total`, and `req_loc_addr`=0.
- R4: With `cmd_far_frag`=0, each non-zero-length descriptor produces one `seg_valid` cycle, in descriptor order. That cycle shows `seg_loc_addr`=descriptor base, `seg_len`=descriptor length, and `seg_offset`=the sum of the earlier lengths.
- R5: A zero-length descriptor produces neither a request nor a segment entry, and no request of zero length is ever issued.
- R6: The number of requests issued but not yet answered never exceeds `MAX_OUT` (4 by default).
- R7: A request that is not accepted stays valid, with the same address and length, on the following cycle.
- R8: `done` is a single-cycle pulse. It comes only after the descriptor walk has finished and one `rsp_valid` cycle has been seen for every accepted request.
- R9: `len_err` is high together with `done` exactly when the sum of the descriptor lengths differs from `cmd_total`.
- R10: `req_write` equals the `cmd_write` value of the current command on every issued request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_write | input | 1 | 1 = write to far memory, 0 = read from far memory |
| cmd_far_frag | input | 1 | 1 = disjoint buffers are in far memory, 0 = in local memory |
| cmd_base | input | AW | Base of the contiguous range |
| cmd_total | input | TW | Total bytes of the command |
| cmd_count | input | IW+1 | Number of descriptors |
| desc_idx | output | IW | Descriptor being looked up |
| desc_base | input | AW | Base of descriptor `desc_idx` |
| desc_len | input | LW | Length of descriptor `desc_idx` |
| req_valid | output | 1 | Far request present |
| req_ready | input | 1 | Far request accepted |
| req_write | output | 1 | Request direction |
| req_far_addr | output | AW | Far memory address |
| req_loc_addr | output | AW | Local address (0 when local placement is on the segment stream) |
| req_len | output | TW | Request length in bytes |
| rsp_valid | input | 1 | One request has completed |
| seg_valid | output | 1 | Local placement entry present |
| seg_loc_addr | output | AW | Local buffer base |
| seg_offset | output | TW | Offset of this buffer within the contiguous range |
| seg_len | output | LW | Buffer length |
| done | output | 1 | Command complete (one cycle) |
| len_err | output | 1 | Descriptor lengths disagree with total, valid with `done` |

## Verification
A wrong walk index or running offset shows up on the first request or segment entry after the fault. That entry carries the wrong address, offset or length, and it is compared the cycle it is handed over. A wrong outstanding count shows in one of two ways. Either `done` comes while responses are still owed, which is caught that cycle, or the count passes the in-flight limit, which is caught on the next accepted request. A skipped or repeated descriptor leaves the expected transfer list non-empty when `done` arrives. A bad length sum shows as a wrong `len_err` on the done pulse.

// File: rtl/sg_sequencer.sv
module sg_sequencer #(
  parameter int AW      = 32,
  parameter int LW      = 16,
  parameter int IW      = 4,
  parameter int MAX_OUT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic          cmd_far_frag,
  input  logic [AW-1:0] cmd_base,
  input  logic [LW+IW-1:0] cmd_total,
  input  logic [IW:0]   cmd_count,
  output logic [IW-1:0] desc_idx,
  input  logic [AW-1:0] desc_base,
  input  logic [LW-1:0] desc_len,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_far_addr,
  output logic [AW-1:0] req_loc_addr,
  output logic [LW+IW-1:0] req_len,
  input  logic          rsp_valid,
  output logic          seg_valid,
  output logic [AW-1:0] seg_loc_addr,
  output logic [LW+IW-1:0] seg_offset,
  output logic [LW-1:0] seg_len,
  output logic          done,
  output logic          len_err
);
  localparam int TW = LW + IW;
  localparam int CW = IW + 1;
  localparam int OW = $clog2(MAX_OUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_HEAD, S_WALK, S_DRAIN} state_t;

  state_t          st;
  logic            wr_q, far_q;
  logic [AW-1:0]   base_q;
  logic [TW-1:0]   total_q;
  logic [CW-1:0]   cnt_q, idx;
  logic [TW-1:0]   off;
  logic [OW-1:0]   outst;

  logic walking, live, fire, step, rsp_ok, has_room;

  assign has_room  = outst < OW'(MAX_OUT);
  assign walking   = (st == S_WALK) && (idx != cnt_q);
  assign live      = walking && (desc_len != '0);
  assign cmd_ready = (st == S_IDLE);
  assign desc_idx  = idx[IW-1:0];

  assign req_valid    = (st == S_HEAD) || (far_q && live && has_room);
  assign req_write    = wr_q;
  assign req_far_addr = (st == S_HEAD) ? base_q : desc_base;
  assign req_loc_addr = (st == S_HEAD) ? '0 : base_q + AW'(off);
  assign req_len      = (st == S_HEAD) ? total_q : TW'(desc_len);

  assign seg_valid    = !far_q && live;
  assign seg_loc_addr = desc_base;
  assign seg_offset   = off;
  assign seg_len      = desc_len;

  assign fire   = req_valid && req_ready;
  assign rsp_ok = rsp_valid && (outst != '0);
  assign step   = walking && ((desc_len == '0) || !far_q || fire);

  assign done    = (st == S_DRAIN) && (outst == '0);
  assign len_err = done && (off != total_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wr_q    <= 1'b0;
      far_q   <= 1'b0;
      base_q  <= '0;
      total_q <= '0;
      cnt_q   <= '0;
      idx     <= '0;
      off     <= '0;
      outst   <= '0;
    end else begin
      outst <= outst + OW'(fire) - OW'(rsp_ok);
      case (st)
        S_IDLE: if (cmd_valid) begin
          wr_q    <= cmd_write;
          far_q   <= cmd_far_frag;
          base_q  <= cmd_base;
          total_q <= cmd_total;
          cnt_q   <= cmd_count;
          idx     <= '0;
          off     <= '0;
          st      <= (!cmd_far_frag && cmd_total != '0) ? S_HEAD : S_WALK;
        end
        S_HEAD: if (req_ready) st <= S_WALK;
        S_WALK: begin
          if (step) begin
            idx <= idx + 1'b1;
            off <= off + TW'(desc_len);
          end
          if (!walking) st <= S_DRAIN;
        end
        default: if (outst == '0) st <= S_IDLE;
      endcase
    end
  end

  // R6
  outst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= OW'(MAX_OUT));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_far_addr) && $stable(req_len));

  // R3
  seg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> !req_valid);

  // R5
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid |-> req_len != '0) and (seg_valid |-> seg_len != '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_ready);
endmodule

// File: tb/tb_sg_sequencer.sv
`timescale 1ns/1ps
module tb_sg_sequencer;
  localparam int AW = 32, LW = 16, IW = 4, MAX_OUT = 4;
  localparam int TW = LW + IW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cmd_valid = 0, cmd_ready, cmd_write = 0, cmd_far_frag = 0;
  logic [AW-1:0] cmd_base = '0;
  logic [TW-1:0] cmd_total = '0;
  logic [IW:0] cmd_count = '0;
  logic [IW-1:0] desc_idx;
  logic [AW-1:0] desc_base;
  logic [LW-1:0] desc_len;
  logic req_valid, req_ready = 0, req_write;
  logic [AW-1:0] req_far_addr, req_loc_addr;
  logic [TW-1:0] req_len;
  logic rsp_valid = 0;
  logic seg_valid;
  logic [AW-1:0] seg_loc_addr;
  logic [TW-1:0] seg_offset;
  logic [LW-1:0] seg_len;
  logic done, len_err;

  sg_sequencer #(.AW(AW), .LW(LW), .IW(IW), .MAX_OUT(MAX_OUT)) dut (.*);

  int dbase [16];
  int dlen  [16];
  assign desc_base = AW'(dbase[desc_idx]);
  assign desc_len  = LW'(dlen[desc_idx]);

  int vectors = 0, errors = 0;
  int eq_far[$], eq_loc[$], eq_len[$];
  int sq_loc[$], sq_off[$], sq_len[$];
  int pend = 0;
  bit busy = 0, got_done = 0, exp_err = 0, exp_wr = 0, slow = 0, rnd_rdy = 0;
  bit prev_hold = 0;
  logic [AW-1:0] prev_addr;
  logic [TW-1:0] prev_len;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      req_ready = rnd_rdy ? lf[1] : 1'b1;
      rsp_valid = (pend > 0) && (slow ? (lf[4:2] == 3'd0) : lf[0]);
      if (rsp_valid) pend--;
      #1;
      if (prev_hold) begin
        chk(req_valid, "R7 valid held", req_valid, 1);
        chk(req_far_addr == prev_addr && req_len == prev_len, "R7 addr/len held", req_far_addr, prev_addr);
      end
      prev_hold = req_valid && !req_ready;
      prev_addr = req_far_addr;
      prev_len  = req_len;
      if (req_valid && req_ready) begin
        if (eq_far.size() == 0) chk(0, "R2/R3/R5 unexpected request", req_far_addr, -1);
        else begin
          int ef, el, en;
          ef = eq_far.pop_front(); el = eq_loc.pop_front(); en = eq_len.pop_front();
          chk(req_far_addr == AW'(ef), "R2/R3 far addr", req_far_addr, ef);
          chk(req_loc_addr == AW'(el), "R2/R3 local addr", req_loc_addr, el);
          chk(req_len == TW'(en), "R2/R3 length", req_len, en);
          chk(req_write == exp_wr, "R10 direction", req_write, exp_wr);
        end
        pend++;
      end
      if (seg_valid) begin
        chk(eq_far.size() == 0, "R3 head before segments", eq_far.size(), 0);
        if (sq_loc.size() == 0) chk(0, "R4/R5 unexpected segment", seg_loc_addr, -1);
        else begin
          int sl, so, sn;
          sl = sq_loc.pop_front(); so = sq_off.pop_front(); sn = sq_len.pop_front();
          chk(seg_loc_addr == AW'(sl), "R4 seg addr", seg_loc_addr, sl);
          chk(seg_offset == TW'(so), "R4 seg offset", seg_offset, so);
          chk(seg_len == LW'(sn), "R4 seg len", seg_len, sn);
        end
      end
      chk(pend <= MAX_OUT, "R6 in-flight limit", pend, MAX_OUT);
      if (busy && cmd_ready) chk(0, "R1 ready while busy", cmd_ready, 0);
      if (done) begin
        chk(pend == 0 && !rsp_valid, "R8 responses owed at done", pend, 0);
        chk(eq_far.size() + sq_loc.size() == 0, "R5/R8 transfers missing at done",
            eq_far.size() + sq_loc.size(), 0);
        chk(len_err == exp_err, "R9 length error", len_err, exp_err);
        got_done = 1;
        busy = 0;
      end
    end
  end

  task automatic run(input bit wr, input bit far, input int base, input int cnt,
                     input int adj, input bit slw, input bit rr);
    int sum, total;
    sum = 0;
    for (int i = 0; i < cnt; i++) sum += dlen[i];
    total = sum + adj;
    @(negedge clk); #2;
    chk(cmd_ready, "R1 idle ready", cmd_ready, 1);
    exp_wr = wr; exp_err = (adj != 0); slow = slw; rnd_rdy = rr; got_done = 0;
    if (far) begin
      int off;
      off = 0;
      for (int i = 0; i < cnt; i++) if (dlen[i] != 0) begin
        eq_far.push_back(dbase[i]); eq_loc.push_back(base + off); eq_len.push_back(dlen[i]);
        off += dlen[i];
      end
    end else begin
      int off;
      off = 0;
      if (total != 0) begin
        eq_far.push_back(base); eq_loc.push_back(0); eq_len.push_back(total);
      end
      for (int i = 0; i < cnt; i++) if (dlen[i] != 0) begin
        sq_loc.push_back(dbase[i]); sq_off.push_back(off); sq_len.push_back(dlen[i]);
        off += dlen[i];
      end
    end
    cmd_write = wr; cmd_far_frag = far; cmd_base = AW'(base);
    cmd_total = TW'(total); cmd_count = (IW+1)'(cnt); cmd_valid = 1;
    @(posedge clk); #1;
    cmd_valid = 0; busy = 1;
    for (int t = 0; t < 3000 && !got_done; t++) @(negedge clk);
    if (!got_done) chk(0, "R8 done never seen", 0, 1);
    eq_far.delete(); eq_loc.delete(); eq_len.delete();
    sq_loc.delete(); sq_off.delete(); sq_len.delete();
    pend = 0; busy = 0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin dbase[i] = 'h1000 * (i + 1); dlen[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #2;
    chk(cmd_ready && !req_valid && !seg_valid && !done, "R1 reset state", cmd_ready, 1);

    // R2 R5: far fragments, read, one zero descriptor
    dlen[0] = 8; dlen[1] = 0; dlen[2] = 16; dlen[3] = 4; dlen[4] = 12;
    run(0, 1, 'h200, 5, 0, 0, 0);
    // R6 R7 R10: far fragments, write, slow responses, random ready
    for (int i = 0; i < 12; i++) dlen[i] = (i % 4 == 3) ? 0 : i + 1;
    run(1, 1, 'h8000, 12, 0, 1, 1);
    // R3 R4: local fragments, read
    for (int i = 0; i < 6; i++) dlen[i] = (i == 2) ? 0 : 3 * i + 5;
    run(0, 0, 'h4400, 6, 0, 0, 1);
    // R4 R5: local fragments, write, zero first and last
    for (int i = 0; i < 7; i++) dlen[i] = (i == 0 || i == 6) ? 0 : 64;
    run(1, 0, 'h100, 7, 0, 1, 1);
    // R9: mismatch in both modes
    run(0, 1, 'h300, 7, 5, 0, 1);
    run(1, 0, 'h300, 7, -3, 0, 0);
    // R5 R8: empty list and all-zero lists
    run(0, 1, 'h10, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) dlen[i] = 0;
    run(1, 1, 'h10, 3, 0, 0, 0);
    run(0, 0, 'h10, 3, 0, 0, 0);
    // R6: full list, far fragments, slow responses
    for (int i = 0; i < 16; i++) dlen[i] = 2 * i + 1;
    run(1, 1, 'h0, 16, 0, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule